// File: doc/BRIEF.md
# Cascade Hit Arbiter

This block sits beside the match array of one search device in a chain of depth-cascaded devices. Each search presents the same key to every device at the same time. Each device reports whether it has a local match. Devices nearer address 0 of the combined table report their own hits to the devices behind them, on a per-block line and on a per-group line. A device decides that it is the global winner only when it has a local match and none of the hit lines from upstream is active.

The winner drives the success flag, its valid qualifier and the lookup address towards the associated-data memory. That address is made from the device ID and the winning index. Two devices can be marked as defaults. The flag-default device reports a miss, or an idle cycle, when no other device drives the flags. The memory-default device parks the memory bus at its inactive values when no other device drives it. The success outputs can be delayed by a further 0 to 7 cycles, to line them up with the data coming back from that memory.

Each search names one of eight result slots. The slot keeps the local index whenever the device has a local hit, and its valid bit is set only when the device wins. A slot can be read back by device ID, or by the all-ones broadcast ID. A broadcast read is answered only by the flag-default device. Clearing the enable input makes the device fall silent on all of its shared lines. Every shared output comes with an output-enable, which stands for the tristate driver.

Top module: `cascade_hit_arbiter`

## Requirements
- R1: `lhit_o` is `dev_en & srch_vld & loc_hit`, visible the cycle after the search is sampled. `bhit_o` is high one cycle later when the device is enabled and there was any hit: its own hit, any bit of `up_lhit`, or any bit of `up_bhit`.
- R2: The `up_lhit` and `up_bhit` lines of a search are sampled one cycle after its `srch_vld`. The device wins only if it had a local hit and every one of those bits was 0.
- R3: A winning device drives `ss_oe=1`, `ss_flag=1` and `ss_valid=1`, 2+`lat_sel` cycles after the search is sampled.
- R4: When it does not win, a device with `last_dev=1` drives `ss_oe=1` and `ss_flag=0`. It sets `ss_valid=1` on a search where no device hit, and `ss_valid=0` on a non-search cycle.
- R5: A device that neither wins nor is flag default leaves `ss_oe=0`. This includes the flag-default device on a search that another device wins.
- R6: `lat_sel` (0 to 7) adds exactly that many cycles to the success outputs. The memory bus keeps a fixed delay of 2 cycles.
- R7: A winner drives `mem_oe=1`, `mem_addr` = zero-extended {`dev_id`, index}, `mem_ce_n=0`, `mem_ale_n=0` and `mem_we_n=1`, 2 cycles after the search is sampled.
- R8: In a cycle where no device had a hit, a device with `last_mem=1` drives `mem_oe=1`, an all-ones `mem_addr` and `mem_ce_n`, `mem_we_n`, `mem_ale_n` all at 1.
- R9: While `dev_en=0`, these outputs stay low: `ss_oe`, `mem_oe`, `lhit_o`, `bhit_o` and `rd_ack`.
- R10: The slot named by `res_sel` takes the index on a local hit. Its valid bit is set only on a global win, and only reset clears it.
- R11: A read is answered with `rd_ack` one cycle later in two cases: `rd_id` equals `dev_id`, or `rd_id` is all ones (broadcast) and `last_dev=1`. The answer carries `rd_vld` and `rd_idx` of slot `rd_sel`. Any other read gets no answer.
- R12: During reset every output-enable, `lhit_o`, `bhit_o` and `rd_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_en | input | 1 | Device enable; 0 isolates all shared outputs |
| last_dev | input | 1 | Flag-default device, also answers broadcast reads |
| last_mem | input | 1 | Memory-bus default device |
| lat_sel | input | 3 | Extra cycles added to the success outputs |
| dev_id | input | 5 | This device's ID |
| srch_vld | input | 1 | A search result is presented this cycle |
| loc_hit | input | 1 | Local match from the array |
| loc_idx | input | 16 | Local matching index |
| res_sel | input | 3 | Result slot for this search |
| up_lhit | input | 7 | Hit lines from upstream devices in the block |
| up_bhit | input | 3 | Hit lines from upstream blocks |
| rd_req | input | 1 | Result read request |
| rd_id | input | 5 | Target ID of the read, all ones for broadcast |
| rd_sel | input | 3 | Slot to read |
| lhit_o | output | 1 | Local hit to downstream devices |
| bhit_o | output | 1 | Any hit so far, to downstream blocks |
| ss_flag | output | 1 | Search successful |
| ss_valid | output | 1 | Qualifier for ss_flag |
| ss_oe | output | 1 | Drive enable for ss_flag and ss_valid |
| mem_addr | output | 24 | Associated-memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ale_n | output | 1 | Memory address latch, active low |
| mem_oe | output | 1 | Drive enable for the memory bus |
| rd_ack | output | 1 | Read answered |
| rd_vld | output | 1 | Valid bit of the slot read |
| rd_idx | output | 16 | Index of the slot read |

## Verification
The hardest case to reach is a device that has a local hit but loses. The upstream hit lines that cause the loss arrive one cycle after the search that they qualify. The driver therefore carries each search's upstream pattern into the next cycle, so back-to-back searches mix wins, losses and misses. Each default device is also run on a search that a different device wins, where it must stay off the bus. The latency is changed only after the pipeline has drained, and each delay setting gets its own burst of searches.

// File: rtl/cha_pkg.sv
package cha_pkg;
  typedef struct packed {
    logic srch;   // search cycle
    logic lhit;   // local hit on a search
    logic win;    // global winner
    logic any;    // some device in the cascade hit
  } hit_flags_t;
endpackage

// File: rtl/cha_win_stage.sv
module cha_win_stage
  import cha_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int N_LHI = 7,
  parameter int N_BHI = 3,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srch_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_LHI-1:0] up_lhit_i,
  input  logic [N_BHI-1:0] up_bhit_i,
  output logic             lhit_q_o,
  output hit_flags_t       flags_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SEL_W-1:0] sel_o
);
  logic             s1_srch, s1_hit;
  logic [IDX_W-1:0] s1_idx;
  logic [SEL_W-1:0] s1_sel;
  logic             up_any;

  // first stage: register the local result
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_srch <= 1'b0;
      s1_hit  <= 1'b0;
    end else begin
      s1_srch <= srch_i;
      s1_hit  <= srch_i & hit_i;
    end
    s1_idx <= idx_i;
    s1_sel <= sel_i;
  end

  assign lhit_q_o = s1_hit;
  assign up_any   = (|up_lhit_i) | (|up_bhit_i);

  // second stage: combine with upstream hits that line up with stage one
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
    end else begin
      flags_o.srch <= s1_srch;
      flags_o.lhit <= s1_hit;
      flags_o.win  <= s1_hit & ~up_any;
      flags_o.any  <= s1_srch & (s1_hit | up_any);
    end
    idx_o <= s1_idx;
    sel_o <= s1_sel;
  end

  AST_WIN_HAS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    flags_o.win |-> $past(lhit_q_o)); // R2
  AST_UPSTREAM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    $past(up_any) |-> !flags_o.win); // R2
endmodule

// File: rtl/cha_hit_delay.sv
module cha_hit_delay
  import cha_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  hit_flags_t       d_i,
  input  logic [LAT_W-1:0] lat_i,
  output hit_flags_t       q_o
);
  localparam int DEPTH = (1 << LAT_W) - 1;

  hit_flags_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  always_comb begin
    q_o = d_i;
    for (int k = 1; k <= DEPTH; k++) begin
      if (lat_i == LAT_W'(k)) q_o = stage_q[k-1];
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (lat_i == LAT_W'(1)) |-> (q_o == $past(d_i))); // R6
endmodule

// File: rtl/cha_result_regs.sv
module cha_result_regs #(
  parameter int N     = 8,
  parameter int IDX_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_idx_i,
  input  logic             set_vld_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic             rd_vld_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  logic [IDX_W-1:0] idx_mem [N];
  logic [N-1:0]     vld_q;

  // index storage: no reset, registered read
  always_ff @(posedge clk) begin
    if (wr_idx_i) idx_mem[wsel_i] <= widx_i;
    rd_idx_o <= idx_mem[rsel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (set_vld_i) vld_q[wsel_i] <= 1'b1;
      rd_vld_o <= vld_q[rsel_i];
    end
  end

  AST_VLD_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((vld_q & $past(vld_q)) == $past(vld_q))); // R10
endmodule

// File: rtl/cascade_hit_arbiter.sv
module cascade_hit_arbiter
  import cha_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ID_W   = 5,
  parameter int SADR_W = 24,
  parameter int N_LHI  = 7,
  parameter int N_BHI  = 3,
  parameter int N_SSR  = 8,
  parameter int LAT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dev_en,
  input  logic                     last_dev,
  input  logic                     last_mem,
  input  logic [LAT_W-1:0]         lat_sel,
  input  logic [ID_W-1:0]          dev_id,
  input  logic                     srch_vld,
  input  logic                     loc_hit,
  input  logic [IDX_W-1:0]         loc_idx,
  input  logic [$clog2(N_SSR)-1:0] res_sel,
  input  logic [N_LHI-1:0]         up_lhit,
  input  logic [N_BHI-1:0]         up_bhit,
  input  logic                     rd_req,
  input  logic [ID_W-1:0]          rd_id,
  input  logic [$clog2(N_SSR)-1:0] rd_sel,
  output logic                     lhit_o,
  output logic                     bhit_o,
  output logic                     ss_flag,
  output logic                     ss_valid,
  output logic                     ss_oe,
  output logic [SADR_W-1:0]        mem_addr,
  output logic                     mem_ce_n,
  output logic                     mem_we_n,
  output logic                     mem_ale_n,
  output logic                     mem_oe,
  output logic                     rd_ack,
  output logic                     rd_vld,
  output logic [IDX_W-1:0]         rd_idx
);
  localparam int              SEL_W = $clog2(N_SSR);
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic             lhit_q;
  hit_flags_t       s2_flags, dly_flags;
  logic [IDX_W-1:0] s2_idx;
  logic [SEL_W-1:0] s2_sel;

  cha_win_stage #(
    .IDX_W(IDX_W), .N_LHI(N_LHI), .N_BHI(N_BHI), .SEL_W(SEL_W)
  ) u_win (
    .clk(clk), .rst(rst),
    .srch_i(srch_vld), .hit_i(loc_hit), .idx_i(loc_idx), .sel_i(res_sel),
    .up_lhit_i(up_lhit), .up_bhit_i(up_bhit),
    .lhit_q_o(lhit_q), .flags_o(s2_flags), .idx_o(s2_idx), .sel_o(s2_sel)
  );

  cha_hit_delay #(.LAT_W(LAT_W)) u_dly (
    .clk(clk), .rst(rst), .d_i(s2_flags), .lat_i(lat_sel), .q_o(dly_flags)
  );

  cha_result_regs #(.N(N_SSR), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_idx_i(s2_flags.lhit), .set_vld_i(s2_flags.win),
    .wsel_i(s2_sel), .widx_i(s2_idx), .rsel_i(rd_sel),
    .rd_vld_o(rd_vld), .rd_idx_o(rd_idx)
  );

  // cascade outputs: gated register outputs
  assign lhit_o = dev_en & lhit_q;
  assign bhit_o = dev_en & s2_flags.any;

  // success flag and qualifier, after the programmable delay
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_oe    <= 1'b0;
      ss_flag  <= 1'b0;
      ss_valid <= 1'b0;
    end else begin
      ss_oe    <= 1'b0;
      ss_flag  <= 1'b0;
      ss_valid <= 1'b0;
      if (dev_en) begin
        if (dly_flags.win) begin
          ss_oe    <= 1'b1;
          ss_flag  <= 1'b1;
          ss_valid <= 1'b1;
        end else if (last_dev && !(dly_flags.srch && dly_flags.any)) begin
          ss_oe    <= 1'b1;
          ss_valid <= dly_flags.srch;
        end
      end
    end
  end

  // associated-memory bus, fixed delay
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_oe    <= 1'b0;
      mem_addr  <= '1;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ale_n <= 1'b1;
    end else begin
      mem_oe    <= 1'b0;
      mem_addr  <= '1;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ale_n <= 1'b1;
      if (dev_en) begin
        if (s2_flags.win) begin
          mem_oe    <= 1'b1;
          mem_addr  <= SADR_W'({dev_id, s2_idx});
          mem_ce_n  <= 1'b0;
          mem_ale_n <= 1'b0;
        end else if (last_mem && !s2_flags.any) begin
          mem_oe <= 1'b1;
        end
      end
    end
  end

  // result read decode
  always_ff @(posedge clk) begin
    if (rst) rd_ack <= 1'b0;
    else rd_ack <= dev_en & rd_req &
                   (((rd_id == dev_id) && (rd_id != BCAST)) ||
                    ((rd_id == BCAST) && last_dev));
  end

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    ss_flag |-> (ss_valid && ss_oe)); // R3
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    $past(!dev_en) |-> (!ss_oe && !mem_oe && !rd_ack)); // R9
  AST_MEM_PARKED: assert property (@(posedge clk) disable iff (rst)
    (mem_oe && mem_ce_n) |-> ((mem_addr == '1) && mem_we_n && mem_ale_n)); // R8
  AST_BCAST_LAST: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && ($past(rd_id) == BCAST)) |-> $past(last_dev)); // R11
endmodule

// File: tb/cascade_hit_arbiter_bench.sv
module cascade_hit_arbiter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, dev_en, last_dev, last_mem, srch_vld, loc_hit, rd_req;
  logic [2:0]  lat_sel, res_sel, up_bhit, rd_sel;
  logic [4:0]  dev_id, rd_id;
  logic [15:0] loc_idx, rd_idx;
  logic [6:0]  up_lhit;
  logic        lhit_o, bhit_o, ss_flag, ss_valid, ss_oe;
  logic [23:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_ale_n, mem_oe, rd_ack, rd_vld;

  cascade_hit_arbiter u_cascade_hit_arbiter (
    .clk(clk), .rst(rst), .dev_en(dev_en), .last_dev(last_dev), .last_mem(last_mem),
    .lat_sel(lat_sel), .dev_id(dev_id), .srch_vld(srch_vld), .loc_hit(loc_hit),
    .loc_idx(loc_idx), .res_sel(res_sel), .up_lhit(up_lhit), .up_bhit(up_bhit),
    .rd_req(rd_req), .rd_id(rd_id), .rd_sel(rd_sel), .lhit_o(lhit_o), .bhit_o(bhit_o),
    .ss_flag(ss_flag), .ss_valid(ss_valid), .ss_oe(ss_oe), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_ale_n(mem_ale_n), .mem_oe(mem_oe),
    .rd_ack(rd_ack), .rd_vld(rd_vld), .rd_idx(rd_idx)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    int          kind;  // 0 lhit, 1 bhit, 2 success, 3 memory bus
    logic [31:0] exp;
    string       req;
  } exp_t;
  exp_t sbq[$];

  logic [6:0]  pend_l;
  logic [2:0]  pend_b;
  logic [15:0] m_idx [8];
  logic        m_vld [8];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] actual_of(input int kind);
    case (kind)
      0: return {31'd0, lhit_o};
      1: return {31'd0, bhit_o};
      2: return {29'd0, ss_oe, ss_flag, ss_valid};
      default: return mem_oe ? {4'd0, 1'b1, mem_addr, mem_ce_n, mem_we_n, mem_ale_n} : 32'd0;
    endcase
  endfunction

  // monitor: compare every expected item in the cycle it falls due
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        check(sbq[i].req, actual_of(sbq[i].kind), sbq[i].exp);
        sbq.delete(i);
      end
    end
  end

  task automatic push(input int due, input int kind, input logic [31:0] exp, input string req);
    exp_t e;
    e.due = due; e.kind = kind; e.exp = exp; e.req = req;
    sbq.push_back(e);
  endtask

  // driver: one search slot per call; upstream lines follow one cycle later
  task automatic op(input logic s, input logic h, input logic [15:0] ix, input logic [2:0] sel,
                    input logic [6:0] ul, input logic [2:0] ub);
    int k;
    logic win, any;
    @(negedge clk);
    srch_vld = s; loc_hit = h; loc_idx = ix; res_sel = sel;
    up_lhit = pend_l; up_bhit = pend_b;
    pend_l = ul; pend_b = ub;
    k = cyc + 1;
    win = s & h & (ul == 0) & (ub == 0);
    any = s & (h | (ul != 0) | (ub != 0));
    push(k, 0, {31'd0, dev_en & s & h}, dev_en ? "R1" : "R9");
    push(k + 1, 1, {31'd0, dev_en & any}, dev_en ? "R1 R2" : "R9");
    if (!dev_en)       push(k + 2 + int'(lat_sel), 2, 32'd0, "R9");
    else if (win)      push(k + 2 + int'(lat_sel), 2, 32'd7, "R3 R6");
    else if (last_dev && !(s && any))
                       push(k + 2 + int'(lat_sel), 2, {29'd0, 2'b10, s}, "R4 R6");
    else               push(k + 2 + int'(lat_sel), 2, 32'd0, "R5");
    if (!dev_en)       push(k + 2, 3, 32'd0, "R9");
    else if (win)      push(k + 2, 3, {4'd0, 1'b1, 3'd0, dev_id, ix, 3'b010}, "R7");
    else if (last_mem && !any)
                       push(k + 2, 3, {4'd0, 1'b1, 24'hFFFFFF, 3'b111}, "R8");
    else               push(k + 2, 3, 32'd0, "R7 R8");
    if (s && h) m_idx[sel] = ix;   // R10 model
    if (win) m_vld[sel] = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    srch_vld = 0; loc_hit = 0; up_lhit = pend_l; up_bhit = pend_b;
    pend_l = 0; pend_b = 0;
    repeat (12) begin
      @(negedge clk);
      up_lhit = 0; up_bhit = 0;
    end
  endtask

  task automatic rd(input logic [4:0] id, input logic [2:0] sel, input logic exp_ack, input string req);
    @(negedge clk);
    rd_req = 1; rd_id = id; rd_sel = sel;
    @(negedge clk);
    rd_req = 0;
    check(req, {31'd0, rd_ack}, {31'd0, exp_ack});
    if (exp_ack) check(req, {15'd0, rd_vld, rd_idx}, {15'd0, m_vld[sel], m_idx[sel]});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_idx[i] = 0; m_vld[i] = 0; end
    rst = 1; dev_en = 1; last_dev = 0; last_mem = 0; lat_sel = 0; dev_id = 5'd3;
    srch_vld = 0; loc_hit = 0; loc_idx = 0; res_sel = 0; up_lhit = 0; up_bhit = 0;
    rd_req = 0; rd_id = 0; rd_sel = 0; pend_l = 0; pend_b = 0;
    repeat (4) @(negedge clk);
    check("R12", {27'd0, ss_oe, mem_oe, lhit_o, bhit_o, rd_ack}, 32'd0);
    rst = 0;
    repeat (2) @(negedge clk);

    // plain device, no extra delay
    op(1, 1, 16'h0012, 3'd0, 7'h00, 3'h0);   // R2 win
    op(1, 1, 16'h0034, 3'd1, 7'h04, 3'h0);   // R2 lose to block neighbour
    op(1, 0, 16'h0000, 3'd2, 7'h00, 3'h2);   // R5 miss, upstream block hit
    op(1, 1, 16'h0056, 3'd3, 7'h00, 3'h1);   // R2 lose to upstream block
    op(0, 0, 16'h0000, 3'd0, 7'h00, 3'h0);   // idle
    op(1, 0, 16'h0000, 3'd0, 7'h00, 3'h0);   // global miss
    flush();

    // default device on both buses, delay 3
    last_dev = 1; last_mem = 1; lat_sel = 3'd3;
    op(1, 0, 16'h0000, 3'd0, 7'h00, 3'h0);   // R4 miss
    op(0, 0, 16'h0000, 3'd0, 7'h00, 3'h0);   // R4 idle
    op(1, 1, 16'h0ABC, 3'd4, 7'h00, 3'h0);   // R7 win
    op(1, 0, 16'h0000, 3'd0, 7'h40, 3'h0);   // R5 another device wins
    op(1, 1, 16'h0DEF, 3'd5, 7'h00, 3'h4);   // lose
    op(0, 0, 16'h0000, 3'd0, 7'h00, 3'h0);
    flush();

    // deepest delay, back-to-back
    lat_sel = 3'd7; last_dev = 0;
    op(1, 1, 16'h1111, 3'd6, 7'h00, 3'h0);
    op(1, 0, 16'h0000, 3'd0, 7'h00, 3'h0);
    op(1, 1, 16'hFFFF, 3'd7, 7'h00, 3'h0);
    op(1, 1, 16'h2222, 3'd2, 7'h01, 3'h0);
    flush();

    // isolated device
    dev_en = 0; last_dev = 1; lat_sel = 3'd2;
    op(1, 1, 16'h3333, 3'd5, 7'h00, 3'h0);   // R9
    op(1, 0, 16'h0000, 3'd0, 7'h00, 3'h0);
    op(0, 0, 16'h0000, 3'd0, 7'h00, 3'h0);
    flush();
    rd(5'd3, 3'd0, 1'b0, "R9");
    dev_en = 1;
    repeat (2) @(negedge clk);

    // result slots and reads
    rd(5'd3, 3'd0, 1'b1, "R10 R11");
    rd(5'd3, 3'd1, 1'b1, "R10");
    rd(5'd3, 3'd4, 1'b1, "R10");
    rd(5'd3, 3'd5, 1'b1, "R10");
    rd(5'd3, 3'd7, 1'b1, "R10");
    rd(5'd9, 3'd0, 1'b0, "R11");
    rd(5'h1F, 3'd6, 1'b1, "R11");
    last_dev = 0;
    rd(5'h1F, 3'd6, 1'b0, "R11");
    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", sbq.size(), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule